// File: doc/BRIEF.md
# Virtual-Width Vector Operation Sequencer

This block takes one vector instruction that, to the program, acts on sixteen elements at once, and carries it out over several cycles on a narrower set of functional-unit lanes. The operation class picks the unit. Frequent operations such as add go to a four-lane unit and finish in four issue cycles. Rare operations such as reciprocal square root go to a single-lane unit and take sixteen issue cycles. The instruction looks the same in both cases; only its latency differs.

On acceptance the sequencer latches the opcode, its class and a sixteen-bit element mask. It then steps through element groups in ascending order. On each step it routes the source operands of the current group to the lanes and writes the lane results back into a sixteen-entry destination array, at the index of the source element. The arithmetic sits outside the block. The functional unit answers combinationally in the same cycle as the lane operands are presented. The source view must stay stable while the block is busy.

Top module: `vec_seq_top`

## Requirements
- R1: After synchronous active-low reset, `busy` and `done` are 0, `issue_ready` is 1, every `dst` element is 0 and every bit of `fu_lane_en` is 0.
- R2: An opcode with its top bit 0 is in the wide class. It keeps `busy` high for exactly 4 cycles after the accepting edge.
- R3: An opcode with its top bit 1 is in the narrow class. It keeps `busy` high for exactly 16 cycles after the accepting edge.
- R4: In busy cycle k of a wide instruction, lane l carries element 4k+l. In busy cycle k of a narrow instruction, lane 0 carries element k and lanes 1 to 3 are disabled. A lane is enabled only when the mask bit of its element is 1, and no lane is enabled while idle.
- R5: An element whose mask bit (bit e for element e) is 0 keeps its previous `dst` value. It still uses its slot, so the cycle count does not change.
- R6: The result for element e is written to `dst` element e, which occupies bits [16e+15:16e].
- R7: An instruction is accepted only when `issue_valid` is 1 and `busy` is 0. A request made while busy has no effect on timing, lanes or results.
- R8: Opcode, class and mask are captured at acceptance. `fu_op` holds the captured opcode for the whole instruction, even if `issue_op` or `issue_mask` change.
- R9: `done` is high for exactly one cycle: the cycle right after the edge that writes the last group. `busy` falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction request |
| issue_op | input | 2 | Opcode; top bit selects narrow class |
| issue_mask | input | 16 | Per-element write mask |
| src_a | input | 256 | Source view A, 16 elements of 16 bits |
| src_b | input | 256 | Source view B, 16 elements of 16 bits |
| issue_ready | output | 1 | High when an instruction can be accepted |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| fu_op | output | 2 | Captured opcode presented to the units |
| fu_lane_en | output | 4 | Per-lane enable |
| fu_opnd_a | output | 64 | Lane operands A |
| fu_opnd_b | output | 64 | Lane operands B |
| fu_res | input | 64 | Lane results from the functional unit |
| dst | output | 256 | Destination array, 16 elements of 16 bits |

## Verification
The assertions check on every cycle that a run's busy length matches the class of the held opcode. They also check that narrow runs and idle cycles leave the upper lanes off, that the opcode stays stable while busy, that busy starts only on a request, and that done is a single pulse trailing busy. Only the bench's scenarios can show that the right elements reach the right lanes in the right order, that results land at matching destination indices, and that masked elements keep their old values. The bench also shows that requests and opcode changes made while busy leave the outcome unchanged.

// File: rtl/vseq_pkg.sv
// Package: shared types and helpers for the vector sequencer.
// Assumes the opcode's top bit alone selects the functional-unit class.
package vseq_pkg;

    localparam int OP_W = 2;

    typedef enum logic {
        CLS_WIDE   = 1'b0,
        CLS_NARROW = 1'b1
    } unit_cls_t;

    // Decode the unit class from an opcode.
    function automatic unit_cls_t op_class(input logic [OP_W-1:0] op);
        return op[OP_W-1] ? CLS_NARROW : CLS_WIDE;
    endfunction

endpackage

// File: rtl/vseq_ctrl.sv
// Module: vseq_ctrl
// Accepts an instruction when idle, captures opcode, class and mask, and
// steps a group counter until the class's last group; then pulses done.
// Assumes ELEMS divides evenly by both lane counts.
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int ELEMS        = 16,
    parameter int WIDE_LANES   = 4,
    parameter int NARROW_LANES = 1,
    localparam int NGROUPS_W   = ELEMS / WIDE_LANES,
    localparam int NGROUPS_N   = ELEMS / NARROW_LANES,
    localparam int GRPW        = (NGROUPS_N > 1) ? $clog2(NGROUPS_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [OP_W-1:0]   issue_op,
    input  logic [ELEMS-1:0]  issue_mask,
    output logic              busy,
    output logic              done,
    output unit_cls_t         cls_q,
    output logic [OP_W-1:0]   op_q,
    output logic [ELEMS-1:0]  mask_q,
    output logic [GRPW-1:0]   grp
);

    logic [GRPW-1:0] last_grp;
    logic            accept;

    // Final group index for the class currently held.
    always_comb begin
        last_grp = (cls_q == CLS_WIDE) ? GRPW'(NGROUPS_W - 1) : GRPW'(NGROUPS_N - 1);
    end

    // Acceptance condition: request while idle.
    always_comb begin
        accept = issue_valid && !busy;
    end

    // Sequencing state: capture on accept, advance groups, finish with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cls_q  <= CLS_WIDE;
            op_q   <= '0;
            mask_q <= '0;
            grp    <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                grp    <= '0;
                cls_q  <= op_class(issue_op);
                op_q   <= issue_op;
                mask_q <= issue_mask;
            end else if (busy) begin
                if (grp == last_grp) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    grp  <= '0;
                end else begin
                    grp <= grp + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vseq_gather.sv
// Module: vseq_gather
// Routes the current group's source elements onto the functional-unit
// lanes and raises each lane's enable from the captured mask.
// Assumes the source view is stable while busy.
module vseq_gather
    import vseq_pkg::*;
#(
    parameter int ELEMS        = 16,
    parameter int WIDE_LANES   = 4,
    parameter int NARROW_LANES = 1,
    parameter int DW           = 16,
    parameter int GRPW         = 4,
    localparam int IDXW        = $clog2(ELEMS)
) (
    input  logic                     busy,
    input  unit_cls_t                cls_q,
    input  logic [GRPW-1:0]          grp,
    input  logic [ELEMS-1:0]         mask_q,
    input  logic [ELEMS*DW-1:0]      src_a,
    input  logic [ELEMS*DW-1:0]      src_b,
    output logic [WIDE_LANES-1:0]    lane_en,
    output logic [WIDE_LANES*DW-1:0] opnd_a,
    output logic [WIDE_LANES*DW-1:0] opnd_b
);

    for (genvar l = 0; l < WIDE_LANES; l++) begin : g_lane
        logic            active;
        logic [IDXW-1:0] idx;

        // Lane is live when busy and the class uses it.
        always_comb begin
            active = busy && ((cls_q == CLS_WIDE) || (l < NARROW_LANES));
        end

        // Element index served by this lane in the current group.
        always_comb begin
            if (cls_q == CLS_WIDE)
                idx = IDXW'(grp * WIDE_LANES + l);
            else
                idx = IDXW'(grp * NARROW_LANES + l);
        end

        // Drive enable and operands for this lane.
        always_comb begin
            lane_en[l]           = active && mask_q[idx];
            opnd_a[l*DW +: DW]   = active ? src_a[idx*DW +: DW] : '0;
            opnd_b[l*DW +: DW]   = active ? src_b[idx*DW +: DW] : '0;
        end
    end

endmodule

// File: rtl/vseq_collect.sv
// Module: vseq_collect
// Holds the destination array and writes each lane result into the entry
// of the element it was computed for, skipping masked-off elements.
// Assumes results arrive in the same cycle as the lane operands.
module vseq_collect
    import vseq_pkg::*;
#(
    parameter int ELEMS        = 16,
    parameter int WIDE_LANES   = 4,
    parameter int NARROW_LANES = 1,
    parameter int DW           = 16,
    parameter int GRPW         = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     busy,
    input  unit_cls_t                cls_q,
    input  logic [GRPW-1:0]          grp,
    input  logic [ELEMS-1:0]         mask_q,
    input  logic [WIDE_LANES*DW-1:0] fu_res,
    output logic [ELEMS*DW-1:0]      dst
);

    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        localparam int LANE_W = e % WIDE_LANES;
        localparam int LANE_N = e % NARROW_LANES;
        logic          we;
        logic [DW-1:0] wdata;

        // Write enable: element belongs to the current group and is unmasked.
        always_comb begin
            if (cls_q == CLS_WIDE)
                we = busy && mask_q[e] && (grp == GRPW'(e / WIDE_LANES));
            else
                we = busy && mask_q[e] && (grp == GRPW'(e / NARROW_LANES));
        end

        // Pick the lane that carried this element.
        always_comb begin
            wdata = (cls_q == CLS_WIDE) ? fu_res[LANE_W*DW +: DW]
                                        : fu_res[LANE_N*DW +: DW];
        end

        // Destination entry register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dst[e*DW +: DW] <= '0;
            else if (we)
                dst[e*DW +: DW] <= wdata;
        end
    end

endmodule

// File: rtl/vec_seq_top.sv
// Module: vec_seq_top
// Presents a sixteen-element vector instruction and executes it over a
// four-lane or one-lane unit chosen by opcode class.
// Assumes src_a/src_b are stable while busy and fu_res is combinational.
module vec_seq_top
    import vseq_pkg::*;
#(
    parameter int ELEMS        = 16,
    parameter int WIDE_LANES   = 4,
    parameter int NARROW_LANES = 1,
    parameter int DW           = 16,
    localparam int GRPW        = ((ELEMS / NARROW_LANES) > 1) ? $clog2(ELEMS / NARROW_LANES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_valid,
    input  logic [OP_W-1:0]          issue_op,
    input  logic [ELEMS-1:0]         issue_mask,
    input  logic [ELEMS*DW-1:0]      src_a,
    input  logic [ELEMS*DW-1:0]      src_b,
    output logic                     issue_ready,
    output logic                     busy,
    output logic                     done,
    output logic [OP_W-1:0]          fu_op,
    output logic [WIDE_LANES-1:0]    fu_lane_en,
    output logic [WIDE_LANES*DW-1:0] fu_opnd_a,
    output logic [WIDE_LANES*DW-1:0] fu_opnd_b,
    input  logic [WIDE_LANES*DW-1:0] fu_res,
    output logic [ELEMS*DW-1:0]      dst
);

    unit_cls_t        cls_q;
    logic [ELEMS-1:0] mask_q;
    logic [GRPW-1:0]  grp;

    // Ready whenever no instruction is in flight.
    always_comb begin
        issue_ready = !busy;
    end

    vseq_ctrl #(
        .ELEMS(ELEMS), .WIDE_LANES(WIDE_LANES), .NARROW_LANES(NARROW_LANES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_op(issue_op), .issue_mask(issue_mask),
        .busy(busy), .done(done), .cls_q(cls_q), .op_q(fu_op),
        .mask_q(mask_q), .grp(grp)
    );

    vseq_gather #(
        .ELEMS(ELEMS), .WIDE_LANES(WIDE_LANES), .NARROW_LANES(NARROW_LANES),
        .DW(DW), .GRPW(GRPW)
    ) u_gather (
        .busy(busy), .cls_q(cls_q), .grp(grp), .mask_q(mask_q),
        .src_a(src_a), .src_b(src_b),
        .lane_en(fu_lane_en), .opnd_a(fu_opnd_a), .opnd_b(fu_opnd_b)
    );

    vseq_collect #(
        .ELEMS(ELEMS), .WIDE_LANES(WIDE_LANES), .NARROW_LANES(NARROW_LANES),
        .DW(DW), .GRPW(GRPW)
    ) u_collect (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cls_q(cls_q), .grp(grp),
        .mask_q(mask_q), .fu_res(fu_res), .dst(dst)
    );

endmodule

// File: rtl/vseq_checker.sv
// Module: vseq_checker
// Cycle-level properties of the sequencer, bound to vec_seq_top.
// Assumes the opcode's top bit selects the narrow class.
module vseq_checker #(
    parameter int ELEMS        = 16,
    parameter int WIDE_LANES   = 4,
    parameter int NARROW_LANES = 1,
    parameter int OPW          = 2,
    localparam int LENW        = $clog2(ELEMS + 2) + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  issue_valid,
    input logic                  busy,
    input logic                  done,
    input logic [OPW-1:0]        fu_op,
    input logic [WIDE_LANES-1:0] fu_lane_en
);

    logic [LENW-1:0] run_len;

    // Count the busy cycles of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (busy)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    assert_wide_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !fu_op[OPW-1]) |-> (run_len == LENW'(ELEMS / WIDE_LANES)));

    assert_narrow_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && fu_op[OPW-1]) |-> (run_len == LENW'(ELEMS / NARROW_LANES)));

    assert_narrow_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fu_op[OPW-1]) |-> ((fu_lane_en >> NARROW_LANES) == '0));

    assert_idle_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fu_lane_en == '0));

    assert_accept_on_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(issue_valid));

    assert_hold_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fu_op));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

bind vec_seq_top vseq_checker #(
    .ELEMS(ELEMS), .WIDE_LANES(WIDE_LANES), .NARROW_LANES(NARROW_LANES), .OPW(vseq_pkg::OP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .busy(busy),
    .done(done), .fu_op(fu_op), .fu_lane_en(fu_lane_en)
);

// File: tb/sim_vec_seq_top.sv
// Bench: constrained random plus directed instructions against a bench model.
module sim_vec_seq_top;

    localparam int ELEMS = 16;
    localparam int WL    = 4;
    localparam int DW    = 16;
    localparam int OPW   = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                issue_valid = 1'b0;
    logic [OPW-1:0]      issue_op = '0;
    logic [ELEMS-1:0]    issue_mask = '0;
    logic [ELEMS*DW-1:0] src_a = '0;
    logic [ELEMS*DW-1:0] src_b = '0;
    logic                issue_ready, busy, done;
    logic [OPW-1:0]      fu_op;
    logic [WL-1:0]       fu_lane_en;
    logic [WL*DW-1:0]    fu_opnd_a, fu_opnd_b, fu_res;
    logic [ELEMS*DW-1:0] dst;

    logic [DW-1:0] exp_dst [ELEMS];
    int n_cmp = 0;
    int n_bad = 0;
    int seed_val;

    always #2.5 clk = ~clk;

    vec_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_mask(issue_mask), .src_a(src_a), .src_b(src_b),
        .issue_ready(issue_ready), .busy(busy), .done(done), .fu_op(fu_op),
        .fu_lane_en(fu_lane_en), .fu_opnd_a(fu_opnd_a), .fu_opnd_b(fu_opnd_b),
        .fu_res(fu_res), .dst(dst)
    );

    // Placeholder arithmetic for each opcode.
    function automatic logic [DW-1:0] fu_model(logic [OPW-1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return (a >> 1) + 16'd1;
            default: return a ^ b;
        endcase
    endfunction

    // Combinational functional unit.
    always_comb begin
        for (int l = 0; l < WL; l++)
            fu_res[l*DW +: DW] = fu_model(fu_op, fu_opnd_a[l*DW +: DW], fu_opnd_b[l*DW +: DW]);
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one instruction, follow it cycle by cycle and check everything.
    task automatic run_instr(logic [OPW-1:0] op, logic [ELEMS-1:0] mask, bit disturb);
        bit narrow = op[OPW-1];
        int ngrp   = narrow ? ELEMS : ELEMS / WL;
        int cyc    = 0;
        string rq  = narrow ? "R3" : "R2";
        for (int e = 0; e < ELEMS; e++) begin
            src_a[e*DW +: DW] = DW'($urandom);
            src_b[e*DW +: DW] = DW'($urandom);
        end
        @(negedge clk);
        chk("R7", "ready before issue", issue_ready, 1);
        issue_valid = 1'b1; issue_op = op; issue_mask = mask;
        @(negedge clk);
        issue_valid = 1'b0;
        while (busy && cyc < 40) begin
            logic [WL-1:0] en_exp = '0;
            chk("R8", "fu_op held", fu_op, op);
            for (int l = 0; l < WL; l++) begin
                int e = narrow ? cyc : cyc * WL + l;
                if (!narrow || l == 0) begin
                    en_exp[l] = mask[e];
                    chk("R4", "lane operand a", fu_opnd_a[l*DW +: DW], src_a[e*DW +: DW]);
                end
            end
            chk("R4", "lane enables", fu_lane_en, en_exp);
            if (disturb) begin
                issue_valid = 1'b1; issue_op = ~op; issue_mask = ~mask;
            end
            cyc++;
            @(negedge clk);
        end
        issue_valid = 1'b0;
        chk(rq, "busy cycles", cyc, ngrp);
        chk("R9", "done after last group", done, 1);
        for (int e = 0; e < ELEMS; e++)
            if (mask[e])
                exp_dst[e] = fu_model(op, src_a[e*DW +: DW], src_b[e*DW +: DW]);
        for (int e = 0; e < ELEMS; e++)
            chk(mask[e] ? "R6" : "R5", $sformatf("dst[%0d]", e), dst[e*DW +: DW], exp_dst[e]);
        @(negedge clk);
        chk("R9", "done single pulse", done, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'h5eed_0042);
        for (int e = 0; e < ELEMS; e++) exp_dst[e] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "ready after reset", issue_ready, 1);
        chk("R1", "lane enables idle", fu_lane_en, 0);
        chk("R1", "dst cleared", dst, 0);

        run_instr(2'd0, 16'hFFFF, 1'b0);   // R2 wide, full mask
        run_instr(2'd2, 16'hFFFF, 1'b0);   // R3 narrow, full mask
        run_instr(2'd1, 16'h0000, 1'b0);   // R5 all masked, timing unchanged
        run_instr(2'd3, 16'hA5C3, 1'b0);   // R5/R6 narrow sparse mask
        run_instr(2'd0, 16'h8000, 1'b0);   // R6 last element only
        run_instr(2'd1, 16'h0001, 1'b1);   // R7/R8 disturbed wide
        run_instr(2'd2, 16'h5A5A, 1'b1);   // R7/R8 disturbed narrow

        for (int i = 0; i < 40; i++)
            run_instr(OPW'($urandom), ELEMS'($urandom), bit'($urandom & 1));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule